// File: doc/BRIEF.md
# Programmable High/Low-Cycle Clock Divider

This block divides an input clock by a ratio made of two independently programmed parts: the number of input cycles the output spends low and the number it spends high. Each part is a 4-bit field holding its cycle count minus one, so each phase lasts 1 to 16 input cycles. The resulting ratio is any integer from 2 to 32. A bypass control routes the input clock straight to the output, giving divide-by-1.

For odd ratios an optional duty-cycle correction retimes the output edge on the falling input edge, which makes the high and low times equal to half the ratio each. A synchronous sync pulse restarts the divider. It then holds the output low for a programmed number of whole input cycles before the first period begins with its low phase, so several dividers can be aligned with chosen phase steps. The field values are captured only at the start of each low phase. A change made while a period is running therefore never produces a shortened pulse.

Top module: `hlc_clk_div`

## Requirements
- R1: With correction inactive, each low phase of `clk_o` lasts `low_cnt_i`+1 input cycles, from one rising `clk_i` edge to another.
- R2: With correction inactive, each high phase of `clk_o` lasts `high_cnt_i`+1 input cycles.
- R3: The output period is `low_cnt_i`+`high_cnt_i`+2 input cycles, covering every ratio from 2 (both fields 0) to 32 (both fields 15).
- R4: While `bypass_i` is 1, `clk_o` equals `clk_i`.
- R5: Correction is active when the ratio D is odd and `dcc_dis_i` is 0. The output then rises on a rising input edge, stays high for floor(D/2)+0.5 input cycles (falling on a falling input edge) and stays low for floor(D/2)+0.5 input cycles.
- R6: With an even ratio, or with `dcc_dis_i` at 1, the output follows R1 and R2 regardless of the other control.
- R7: A rising clock edge that samples `sync_i` high drives `clk_o` low. If that edge is number e and P is `phase_i`, the first rising output edge comes at rising input edge e+P+L, where L is the low-phase length. With P=0 the period starts at once.
- R8: Values of `low_cnt_i`, `high_cnt_i` and `dcc_dis_i` are captured only at the start of a low phase. A change during a high phase leaves the remaining high time unchanged and applies from the next low phase.
- R9: While `rst_ni` is low and `bypass_i` is 0, `clk_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Synchronous restart with phase offset |
| low_cnt_i | input | 4 | Low-phase length minus one |
| high_cnt_i | input | 4 | High-phase length minus one |
| bypass_i | input | 1 | 1: output is the input clock (divide-by-1) |
| dcc_dis_i | input | 1 | 1: disable odd-ratio duty-cycle correction |
| phase_i | input | 5 | Whole-cycle delay after sync before the first period |
| clk_o | output | 1 | Divided clock |

## Verification
The bench uses the default widths: 4-bit phase fields and a 5-bit phase offset. This puts both ends of the ratio range (2 and 32) and the longest offset of 31 cycles within a run of a few hundred half-cycles. The output is sampled once in each half of every input cycle. This resolves the half-cycle edge placement of the corrected odd ratios as well as the whole-cycle lengths. Randomized field, offset and correction settings are mixed with directed checks at the smallest and largest ratios, at correction on, off and with an even ratio, and at a field change made in mid-period.

// File: rtl/hlc_clk_div_pkg.sv
package hlc_clk_div_pkg;
  typedef enum logic {
    PH_LO = 1'b0,
    PH_HI = 1'b1
  } phase_e;
endpackage

// File: rtl/hlc_clk_div_cfg.sv
module hlc_clk_div_cfg #(
  parameter int FIELD_W = 4,
  localparam int LEN_W  = FIELD_W + 1,
  localparam int D_W    = FIELD_W + 2
) (
  input  logic               rst_ni,
  input  logic [FIELD_W-1:0] low_cnt_i,
  input  logic [FIELD_W-1:0] high_cnt_i,
  input  logic               dcc_dis_i,
  output logic [LEN_W-1:0]   lo_len_o,
  output logic [LEN_W-1:0]   hi_len_o,
  output logic               dcc_en_o
);
  logic [D_W-1:0] ratio;
  logic [D_W-1:0] half;

  always_comb begin
    ratio    = D_W'(low_cnt_i) + D_W'(high_cnt_i) + D_W'(2);
    half     = ratio >> 1;
    dcc_en_o = ratio[0] & ~dcc_dis_i;
    if (dcc_en_o) begin
      hi_len_o = LEN_W'(half);
      lo_len_o = LEN_W'(ratio - half);
    end else begin
      hi_len_o = LEN_W'(high_cnt_i) + LEN_W'(1);
      lo_len_o = LEN_W'(low_cnt_i) + LEN_W'(1);
    end
  end

  // R3: both phases non-empty and summing to the programmed ratio
  always_comb begin
    if (rst_ni) begin
      a_r3_len_range: assert (lo_len_o != '0 && hi_len_o != '0 &&
                              (D_W'(lo_len_o) + D_W'(hi_len_o)) == ratio)
        else $error("a_r3_len_range");
    end
  end
endmodule

// File: rtl/hlc_clk_div_seq.sv
module hlc_clk_div_seq
  import hlc_clk_div_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int PHASE_W = 5,
  localparam int LEN_W  = FIELD_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [LEN_W-1:0]   lo_len_i,
  input  logic [LEN_W-1:0]   hi_len_i,
  input  logic               dcc_en_i,
  output logic               q_o,
  output logic               dcc_o
);
  phase_e             ph_q;
  logic [LEN_W-1:0]   rem_q;
  logic [PHASE_W-1:0] dly_q;
  logic [LEN_W-1:0]   lo_r, hi_r;
  logic               dcc_r;
  logic               bnd;

  // period boundary: start of a low phase, the only point where fields load
  always_comb begin
    if (sync_i)                bnd = (phase_i == '0);
    else if (dly_q != '0)      bnd = (dly_q == PHASE_W'(1));
    else                       bnd = (rem_q == '0) && (ph_q == PH_HI);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_LO;
      rem_q <= '0;
      dly_q <= PHASE_W'(1);
    end else if (bnd) begin
      ph_q  <= PH_LO;
      rem_q <= lo_len_i - LEN_W'(1);
      dly_q <= '0;
    end else if (sync_i) begin
      ph_q  <= PH_LO;
      dly_q <= phase_i;
    end else if (dly_q != '0) begin
      ph_q  <= PH_LO;
      dly_q <= dly_q - PHASE_W'(1);
    end else if (rem_q == '0) begin
      ph_q  <= PH_HI;
      rem_q <= hi_r - LEN_W'(1);
    end else begin
      rem_q <= rem_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_r  <= LEN_W'(1);
      hi_r  <= LEN_W'(1);
      dcc_r <= 1'b0;
    end else if (bnd) begin
      lo_r  <= lo_len_i;
      hi_r  <= hi_len_i;
      dcc_r <= dcc_en_i;
    end
  end

  assign q_o   = (ph_q == PH_HI);
  assign dcc_o = dcc_r;

  // R2: a high phase starts with its captured length
  a_r2_rise_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_o) |-> rem_q == hi_r - LEN_W'(1));
  // R1: a low phase entered outside an offset window starts with its captured length
  a_r1_fall_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(q_o) && dly_q == '0) |-> rem_q == lo_r - LEN_W'(1));
  // R8: captured fields hold between boundaries
  a_r8_hold_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd |=> ($stable(lo_r) && $stable(hi_r) && $stable(dcc_r)));
  // R7: sync forces the low level
  a_r7_sync_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> !q_o);
endmodule

// File: rtl/hlc_clk_div_out.sv
module hlc_clk_div_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic q_i,
  input  logic dcc_i,
  input  logic bypass_i,
  output logic clk_o
);
  logic qn_q;

  // half-cycle retimed copy stretches the high phase for odd ratios
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) qn_q <= 1'b0;
    else         qn_q <= q_i;
  end

  always_comb begin
    if (bypass_i)   clk_o = clk_i;
    else if (dcc_i) clk_o = q_i | qn_q;
    else            clk_o = q_i;
  end

  // R5: the retimed copy lags the core level by exactly half a cycle
  a_r5_half_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qn_q == q_i);
endmodule

// File: rtl/hlc_clk_div.sv
module hlc_clk_div #(
  parameter int FIELD_W = 4,
  parameter int PHASE_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_i,
  input  logic [FIELD_W-1:0] low_cnt_i,
  input  logic [FIELD_W-1:0] high_cnt_i,
  input  logic               bypass_i,
  input  logic               dcc_dis_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic               clk_o
);
  localparam int LEN_W = FIELD_W + 1;

  logic [LEN_W-1:0] lo_len, hi_len;
  logic             dcc_en, q, dcc_act;

  hlc_clk_div_cfg #(.FIELD_W(FIELD_W)) u_cfg (
    .rst_ni    (rst_ni),
    .low_cnt_i (low_cnt_i),
    .high_cnt_i(high_cnt_i),
    .dcc_dis_i (dcc_dis_i),
    .lo_len_o  (lo_len),
    .hi_len_o  (hi_len),
    .dcc_en_o  (dcc_en)
  );

  hlc_clk_div_seq #(.FIELD_W(FIELD_W), .PHASE_W(PHASE_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_i),
    .phase_i (phase_i),
    .lo_len_i(lo_len),
    .hi_len_i(hi_len),
    .dcc_en_i(dcc_en),
    .q_o     (q),
    .dcc_o   (dcc_act)
  );

  hlc_clk_div_out u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .q_i     (q),
    .dcc_i   (dcc_act),
    .bypass_i(bypass_i),
    .clk_o   (clk_o)
  );

  // R9: divided output idles low in reset
  always_comb begin
    if (!rst_ni && !bypass_i) begin
      a_r9_reset_low: assert (clk_o == 1'b0) else $error("a_r9_reset_low");
    end
  end
endmodule

// File: tb/hlc_clk_div_bench.sv
`timescale 1ns/1ps
module hlc_clk_div_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sync_i = 1'b0;
  logic [3:0] low_cnt_i = '0;
  logic [3:0] high_cnt_i = '0;
  logic       bypass_i = 1'b0;
  logic       dcc_dis_i = 1'b0;
  logic [4:0] phase_i = '0;
  logic       clk_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit exp_q [0:1023];
  int ep;

  always #2.5 clk_i = ~clk_i;

  hlc_clk_div u_hlc_clk_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i),
    .low_cnt_i(low_cnt_i), .high_cnt_i(high_cnt_i),
    .bypass_i(bypass_i), .dcc_dis_i(dcc_dis_i),
    .phase_i(phase_i), .clk_o(clk_o)
  );

  task automatic push(bit v, int n);
    for (int i = 0; i < n; i++) begin
      if (ep < 1024) exp_q[ep] = v;
      ep++;
    end
  endtask

  task automatic check(string req, logic got, logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  // One restart with fields (m,n), correction disable dd, offset p.
  // sw=1: fields change to (m2,n2) inside the first high phase (correction off).
  task automatic run_case(string req, int m, int n, bit dd, int p,
                          bit sw, int m2, int n2);
    int d, l, h, hc, lc, l2, h2, nh, kc, bad_h;
    bit dcc;
    logic bad_got;
    d  = m + n + 2;
    l  = m + 1;
    h  = n + 1;
    dcc = (d % 2 == 1) && !dd && !sw;
    hc = d / 2;
    lc = d - hc;
    l2 = m2 + 1;
    h2 = n2 + 1;
    nh = 2 * (p + 3 * d + 4);
    if (sw) nh = 2 * (p + l + h + 2 * (l2 + h2) + 2);
    ep = 0;
    if (dcc) begin
      push(1'b0, 2 * p + 2 * lc);
      while (ep < nh) begin push(1'b1, 2 * hc + 1); push(1'b0, 2 * lc - 1); end
    end else if (sw) begin
      push(1'b0, 2 * p + 2 * l);
      push(1'b1, 2 * h);
      while (ep < nh) begin push(1'b0, 2 * l2); push(1'b1, 2 * h2); end
    end else begin
      push(1'b0, 2 * p + 2 * l);
      while (ep < nh) begin push(1'b1, 2 * h); push(1'b0, 2 * l); end
    end
    kc = p + l + 1;
    @(negedge clk_i);
    low_cnt_i  = 4'(m);
    high_cnt_i = 4'(n);
    dcc_dis_i  = dd;
    phase_i    = 5'(p);
    sync_i     = 1'b1;
    @(posedge clk_i);
    #1 sync_i = 1'b0;
    bad_h = -1;
    bad_got = 1'b0;
    for (int hh = 1; hh < nh; hh++) begin
      if (hh % 2 == 1) begin @(negedge clk_i); #1; end
      else begin @(posedge clk_i); #1; end
      if (sw && hh == 2 * kc) begin
        low_cnt_i  = 4'(m2);
        high_cnt_i = 4'(n2);
      end
      if (hh >= 2 && bad_h < 0 && clk_o !== exp_q[hh]) begin
        bad_h = hh;
        bad_got = clk_o;
      end
    end
    n_run++;
    if (bad_h >= 0) begin
      n_fail++;
      $display("FAIL %s m=%0d n=%0d dd=%0b p=%0d half=%0d: got %0b expected %0b",
               req, m, n, dd, p, bad_h, bad_got, exp_q[bad_h]);
    end
  endtask

  initial begin
    #750000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    #12;
    check("R9 reset low", clk_o, 1'b0);
    rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);

    // R4 bypass
    bypass_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_i); #1 check("R4 bypass high half", clk_o, 1'b1);
      @(negedge clk_i); #1 check("R4 bypass low half", clk_o, 1'b0);
    end
    bypass_i = 1'b0;

    run_case("R3 ratio 2",         0,  0, 1'b1, 0, 1'b0, 0, 0);
    run_case("R3 ratio 32",       15, 15, 1'b0, 0, 1'b0, 0, 0);
    run_case("R1 low length",      5,  1, 1'b0, 0, 1'b0, 0, 0);
    run_case("R2 high length",     0,  9, 1'b0, 0, 1'b0, 0, 0);
    run_case("R6 odd dcc off",     1,  2, 1'b1, 0, 1'b0, 0, 0);
    run_case("R6 even dcc on",     1,  3, 1'b0, 0, 1'b0, 0, 0);
    run_case("R5 ratio 5",         1,  2, 1'b0, 0, 1'b0, 0, 0);
    run_case("R5 ratio 3",         0,  1, 1'b0, 2, 1'b0, 0, 0);
    run_case("R5 ratio 31",       15, 14, 1'b0, 0, 1'b0, 0, 0);
    run_case("R7 offset 31",       0,  1, 1'b1, 31, 1'b0, 0, 0);
    run_case("R7 offset 3",        2,  4, 1'b0, 3, 1'b0, 0, 0);
    run_case("R8 mid-period",      2,  3, 1'b1, 0, 1'b1, 5, 0);
    run_case("R8 mid-period grow", 0,  6, 1'b1, 1, 1'b1, 3, 2);

    for (int i = 0; i < 24; i++) begin
      int m, n, p;
      bit dd;
      m  = int'($urandom_range(15, 0));
      n  = int'($urandom_range(15, 0));
      p  = int'($urandom_range(7, 0));
      dd = 1'($urandom_range(1, 0));
      run_case("R3/R5/R7 random", m, n, dd, p, 1'b0, 0, 0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule